// File: doc/BRIEF.md
# Multi-Level IO Translation Cache

This block is a small, fully associative cache of finished address translations for an IO memory management unit. Each valid entry holds an address-space ID, the input address aligned to the span of the table level that produced it, a granule code, that level, and the translated output address with its permissions. A lookup does not know in advance which level produced the translation. It therefore tests one candidate level per clock. It starts at the first level implied by the granule and the input-size field, and moves towards level 3. At each level it clears the address bits below that level's span. The first level that matches ends the search.

Beside lookup, the block accepts insertion of a completed translation and three kinds of removal: everything, every entry of one address-space ID, and an address range. The range removal takes away an entry when either the entry or the range contains the other. If it carries a level hint, it first tries an exact single-key removal. Two counters record how many lookups hit and how many missed.

The control is a three-state machine. IDLE accepts one request per clock and performs insert, the removals and no-ops in that same clock. A lookup moves IDLE to PROBE. PROBE stays while the current level misses and is below 3, and returns to IDLE on a hit or after level 3. An insert into a full cache flushes every entry and moves IDLE to REFILL. REFILL writes the held entry into slot 0 and always returns to IDLE.

Top module: `mlvl_iotlb`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, both counters are 0 and no entry is valid, so any lookup misses.
- R2: For a lookup, granule code g (1 = 4 KB, 2 = 16 KB, 3 = 64 KB) gives stride 2g+7. The first probed level is 4 − (60 − tsz) / stride, truncated and clamped to 0..3. A miss responds 4 − start clocks after the accepting edge.
- R3: Levels are probed from the start level upwards to 3, one per clock. The level span shift is (2g+10) + (3 − level) × stride. The response arrives level − start + 1 clocks after acceptance, and the first matching level wins. A miss reports level 3.
- R4: A hit needs equal ID, equal masked address, equal level and equal granule code. It returns the stored output address and the 2-bit permission.
- R5: Every lookup response increments exactly one of `hit_count` and `miss_count`. The counters change at no other time.
- R6: An insert (op 1) stores its address masked to the given level's span. If all entries are valid, the block first clears every entry, then writes the new one in the next clock, with `req_ready` low for that clock.
- R7: Op 2 invalidates every entry.
- R8: Op 3 invalidates every entry whose ID equals `req_asid`.
- R9: Op 4 scans by range. Granule code 0 means 4 KB, and the range mask is (pages << granule_log2) − 1. It removes an entry when the request address with the entry's span bits cleared equals the entry address, or when the entry address with the range-mask bits cleared equals the request address. Entries of another ID are skipped unless `req_any_asid` is 1.
- R10: When op 4 has a nonzero level hint, pages = 1 and a specific ID, an entry with exactly that ID, address, granule code and level is removed alone. Only if there is none does the range scan of R9 apply.
- R11: Op codes 0 lookup, 1 insert, 2 invalidate all, 3 invalidate by ID, 4 invalidate by range. Codes 5 to 7 change no entry and no counter, and leave `req_ready` high.
- R12: `rsp_valid` is a single-clock pulse per lookup, and `req_ready` is low while a lookup is probing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block in IDLE, request accepted this clock |
| req_op | input | 3 | Operation code |
| req_asid | input | ASID_W | Address-space ID |
| req_any_asid | input | 1 | Range removal ignores the ID |
| req_addr | input | ADDR_W | Input address |
| req_tg | input | 2 | Granule code |
| req_tsz | input | 6 | Input-size field for lookups |
| req_level | input | 2 | Insert level, or level hint for range removal (0 = none) |
| req_pages | input | PAGE_W | Page count for range removal |
| req_oa | input | OA_W | Output address to insert |
| req_perm | input | PERM_W | Permissions to insert |
| rsp_valid | output | 1 | Lookup result pulse |
| rsp_hit | output | 1 | Lookup hit |
| rsp_oa | output | OA_W | Output address of the hit |
| rsp_perm | output | PERM_W | Permissions of the hit |
| rsp_level | output | 2 | Level of the hit, 3 on a miss |
| hit_count | output | CNT_W | Lookups that hit |
| miss_count | output | CNT_W | Lookups that missed |

## Verification
The bench places a large block and a smaller page in the same region, so that probing in the wrong order returns the page instead of the block. It also times each response against the start level, which exposes a wrong stride or clamp as an early or late pulse. For range removal it covers both directions of containment, the any-ID case and a foreign ID. It covers a level hint that removes only the exact entry and leaves a surrounding block, which a design that always scanned would also remove. It covers a hint that misses and must fall back to the scan. Filling the cache and inserting once more checks that the oldest content is gone and that the refill clock holds `req_ready` low. Unused op codes must leave the stored entries in place.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

    typedef enum logic [2:0] {
        OP_LOOKUP     = 3'd0,
        OP_INSERT     = 3'd1,
        OP_FLUSH      = 3'd2,
        OP_KILL_ID    = 3'd3,
        OP_KILL_RANGE = 3'd4,
        OP_RSV5       = 3'd5,
        OP_RSV6       = 3'd6,
        OP_RSV7       = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROBE  = 2'd1,
        ST_REFILL = 2'd2
    } state_e;

    // bit position of the span boundary for a level and granule code
    function automatic int span_shift(input logic [1:0] tg, input logic [1:0] lvl);
        int g;
        g = 10 + 2 * int'(tg);
        return g + (3 - int'(lvl)) * (g - 3);
    endfunction

    function automatic logic [63:0] low_bits(input int sh);
        if (sh >= 64) return '1;
        return (64'd1 << sh) - 64'd1;
    endfunction

    // first level probed for a granule code and input-size field
    function automatic logic [1:0] first_level(input logic [1:0] tg, input logic [5:0] tsz);
        int stride;
        int lvl;
        stride = 7 + 2 * int'(tg);
        lvl = 4 - (60 - int'(tsz)) / stride;
        if (lvl < 0) lvl = 0;
        if (lvl > 3) lvl = 3;
        return lvl[1:0];
    endfunction

    // mask covering a removal range; code 0 stands for the smallest granule
    function automatic logic [63:0] range_bits(input logic [1:0] tg, input logic [63:0] pages);
        int g;
        g = (tg == 2'd0) ? 12 : 10 + 2 * int'(tg);
        return (pages << g) - 64'd1;
    endfunction

endpackage

// File: rtl/iotlb_store.sv
module iotlb_store
    import iotlb_pkg::*;
#(
    parameter int N      = 8,
    parameter int ASID_W = 16,
    parameter int ADDR_W = 48,
    parameter int OA_W   = 48,
    parameter int PERM_W = 2,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      clr_vec,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_tg,
    input  logic [1:0]        wr_lvl,
    input  logic [OA_W-1:0]   wr_oa,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic [ASID_W-1:0] pr_asid,
    input  logic [ADDR_W-1:0] pr_addr,
    input  logic [1:0]        pr_tg,
    input  logic [1:0]        pr_lvl,
    output logic              pr_hit,
    output logic [OA_W-1:0]   pr_oa,
    output logic [PERM_W-1:0] pr_perm,
    input  logic [ASID_W-1:0] q_asid,
    input  logic              q_any,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [ADDR_W-1:0] q_mask,
    input  logic [1:0]        q_tg,
    input  logic [1:0]        q_lvl,
    output logic [N-1:0]      id_vec,
    output logic [N-1:0]      ex_vec,
    output logic [N-1:0]      rg_vec,
    output logic [IDX_W-1:0]  free_idx,
    output logic              full
);

    logic [N-1:0]      valid_q;
    logic [ASID_W-1:0] e_asid [N];
    logic [ADDR_W-1:0] e_addr [N];
    logic [1:0]        e_tg   [N];
    logic [1:0]        e_lvl  [N];
    logic [OA_W-1:0]   e_oa   [N];
    logic [PERM_W-1:0] e_perm [N];
    logic [N-1:0]      pv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (wr_en && wr_idx == IDX_W'(i)) valid_q[i] <= 1'b1;
                else if (clr_vec[i])              valid_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            e_asid[wr_idx] <= wr_asid;
            e_addr[wr_idx] <= wr_addr;
            e_tg[wr_idx]   <= wr_tg;
            e_lvl[wr_idx]  <= wr_lvl;
            e_oa[wr_idx]   <= wr_oa;
            e_perm[wr_idx] <= wr_perm;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic [ADDR_W-1:0] emask;
        logic              id_eq;
        assign emask     = ADDR_W'(low_bits(span_shift(e_tg[i], e_lvl[i])));
        assign id_eq     = (e_asid[i] == q_asid);
        assign id_vec[i] = valid_q[i] && id_eq;
        assign ex_vec[i] = valid_q[i] && id_eq && (e_addr[i] == q_addr) &&
                           (e_tg[i] == q_tg) && (e_lvl[i] == q_lvl);
        assign rg_vec[i] = valid_q[i] && (q_any || id_eq) &&
                           (((q_addr & ~emask) == e_addr[i]) ||
                            ((e_addr[i] & ~q_mask) == q_addr));
        assign pv[i]     = valid_q[i] && (e_asid[i] == pr_asid) &&
                           (e_addr[i] == pr_addr) && (e_tg[i] == pr_tg) &&
                           (e_lvl[i] == pr_lvl);
    end

    always_comb begin
        logic [IDX_W-1:0] sel;
        sel      = '0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pv[i])       sel      = IDX_W'(i);
            if (!valid_q[i]) free_idx = IDX_W'(i);
        end
        pr_hit  = |pv;
        pr_oa   = e_oa[sel];
        pr_perm = e_perm[sel];
        full    = &valid_q;
    end

endmodule

// File: rtl/iotlb_stats.sv
module iotlb_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump_hit,
    input  logic             bump_miss,
    output logic [CNT_W-1:0] hits,
    output logic [CNT_W-1:0] misses
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hits   <= '0;
            misses <= '0;
        end else begin
            if (bump_hit)  hits   <= hits + CNT_W'(1);
            if (bump_miss) misses <= misses + CNT_W'(1);
        end
    end

endmodule

// File: rtl/mlvl_iotlb.sv
module mlvl_iotlb
    import iotlb_pkg::*;
#(
    parameter int N      = 8,
    parameter int ASID_W = 16,
    parameter int ADDR_W = 48,
    parameter int OA_W   = 48,
    parameter int PERM_W = 2,
    parameter int PAGE_W = 16,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              req_any_asid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_tg,
    input  logic [5:0]        req_tsz,
    input  logic [1:0]        req_level,
    input  logic [PAGE_W-1:0] req_pages,
    input  logic [OA_W-1:0]   req_oa,
    input  logic [PERM_W-1:0] req_perm,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [OA_W-1:0]   rsp_oa,
    output logic [PERM_W-1:0] rsp_perm,
    output logic [1:0]        rsp_level,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    state_e            state_q, state_d;
    op_e               req_kind;
    logic              accept, probe_done, exact_try;
    logic [1:0]        lvl_q;
    logic [ASID_W-1:0] h_asid;
    logic [ADDR_W-1:0] h_addr;
    logic [1:0]        h_tg, h_lvl;
    logic [OA_W-1:0]   h_oa;
    logic [PERM_W-1:0] h_perm;

    logic [N-1:0]      clr_vec, id_vec, ex_vec, rg_vec, kill_vec;
    logic              wr_en, st_full, pr_hit;
    logic [IDX_W-1:0]  wr_idx, free_idx;
    logic [ASID_W-1:0] w_asid;
    logic [ADDR_W-1:0] w_raw, w_addr, pr_addr, q_mask;
    logic [1:0]        w_tg, w_lvl;
    logic [OA_W-1:0]   w_oa, pr_oa;
    logic [PERM_W-1:0] w_perm, pr_perm;

    assign req_kind   = op_e'(req_op);
    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign pr_addr    = h_addr & ~ADDR_W'(low_bits(span_shift(h_tg, lvl_q)));
    assign probe_done = (state_q == ST_PROBE) && (pr_hit || lvl_q == 2'd3);
    assign q_mask     = ADDR_W'(range_bits(req_tg, 64'(req_pages)));
    assign exact_try  = (req_level != 2'd0) && (req_pages == PAGE_W'(1)) && !req_any_asid;
    assign kill_vec   = (exact_try && |ex_vec) ? ex_vec : rg_vec;
    assign w_addr     = w_raw & ~ADDR_W'(low_bits(span_shift(w_tg, w_lvl)));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && req_kind == OP_LOOKUP)             state_d = ST_PROBE;
                else if (accept && req_kind == OP_INSERT && st_full) state_d = ST_REFILL;
            end
            ST_PROBE:  if (probe_done) state_d = ST_IDLE;
            ST_REFILL: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // entry write and clear controls
    always_comb begin
        clr_vec = '0;
        wr_en   = 1'b0;
        wr_idx  = free_idx;
        w_asid  = req_asid;
        w_raw   = req_addr;
        w_tg    = req_tg;
        w_lvl   = req_level;
        w_oa    = req_oa;
        w_perm  = req_perm;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    case (req_kind)
                        OP_INSERT: begin
                            if (st_full) clr_vec = '1;
                            else         wr_en   = 1'b1;
                        end
                        OP_FLUSH:      clr_vec = '1;
                        OP_KILL_ID:    clr_vec = id_vec;
                        OP_KILL_RANGE: clr_vec = kill_vec;
                        default:       clr_vec = '0;
                    endcase
                end
            end
            ST_REFILL: begin
                wr_en  = 1'b1;
                wr_idx = '0;
                w_asid = h_asid;
                w_raw  = h_addr;
                w_tg   = h_tg;
                w_lvl  = h_lvl;
                w_oa   = h_oa;
                w_perm = h_perm;
            end
            default: wr_en = 1'b0;
        endcase
    end

    // registered outputs and request hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_oa    <= '0;
            rsp_perm  <= '0;
            rsp_level <= '0;
            lvl_q     <= '0;
            h_asid    <= '0;
            h_addr    <= '0;
            h_tg      <= '0;
            h_lvl     <= '0;
            h_oa      <= '0;
            h_perm    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        h_asid <= req_asid;
                        h_addr <= req_addr;
                        h_tg   <= req_tg;
                        h_lvl  <= req_level;
                        h_oa   <= req_oa;
                        h_perm <= req_perm;
                        lvl_q  <= first_level(req_tg, req_tsz);
                    end
                end
                ST_PROBE: begin
                    if (probe_done) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= pr_hit;
                        rsp_oa    <= pr_hit ? pr_oa : '0;
                        rsp_perm  <= pr_hit ? pr_perm : '0;
                        rsp_level <= lvl_q;
                    end else begin
                        lvl_q <= lvl_q + 2'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    iotlb_store #(
        .N(N), .ASID_W(ASID_W), .ADDR_W(ADDR_W), .OA_W(OA_W), .PERM_W(PERM_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .clr_vec(clr_vec),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_asid(w_asid), .wr_addr(w_addr),
        .wr_tg(w_tg), .wr_lvl(w_lvl), .wr_oa(w_oa), .wr_perm(w_perm),
        .pr_asid(h_asid), .pr_addr(pr_addr), .pr_tg(h_tg), .pr_lvl(lvl_q),
        .pr_hit(pr_hit), .pr_oa(pr_oa), .pr_perm(pr_perm),
        .q_asid(req_asid), .q_any(req_any_asid), .q_addr(req_addr),
        .q_mask(q_mask), .q_tg(req_tg), .q_lvl(req_level),
        .id_vec(id_vec), .ex_vec(ex_vec), .rg_vec(rg_vec),
        .free_idx(free_idx), .full(st_full)
    );

    iotlb_stats #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst_n(rst_n),
        .bump_hit(probe_done && pr_hit), .bump_miss(probe_done && !pr_hit),
        .hits(hit_count), .misses(miss_count)
    );

endmodule

// File: rtl/iotlb_chk.sv
module iotlb_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [2:0]       req_op,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [1:0]       rsp_level,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count
);

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R12

    AST_BUSY_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 3'd0) |=> !req_ready); // R12

    AST_MISS_AT_L3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> rsp_level == 2'd3); // R3

    AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> hit_count == $past(hit_count) + CNT_W'(1)); // R5

    AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> miss_count == $past(miss_count) + CNT_W'(1)); // R5

    AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ($stable(hit_count) && $stable(miss_count))); // R5

    AST_RSV_OP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op > 3'd4) |=> req_ready); // R11

endmodule

bind mlvl_iotlb iotlb_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_level(rsp_level), .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/mlvl_iotlb_test.sv
module mlvl_iotlb_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [15:0] req_asid = '0;
    logic        req_any_asid = 1'b0;
    logic [47:0] req_addr = '0;
    logic [1:0]  req_tg = '0;
    logic [5:0]  req_tsz = '0;
    logic [1:0]  req_level = '0;
    logic [15:0] req_pages = '0;
    logic [47:0] req_oa = '0;
    logic [1:0]  req_perm = '0;
    logic        rsp_valid, rsp_hit;
    logic [47:0] rsp_oa;
    logic [1:0]  rsp_perm, rsp_level;
    logic [31:0] hit_count, miss_count;

    always #10 clk = ~clk;

    mlvl_iotlb uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_asid(req_asid), .req_any_asid(req_any_asid),
        .req_addr(req_addr), .req_tg(req_tg), .req_tsz(req_tsz),
        .req_level(req_level), .req_pages(req_pages), .req_oa(req_oa),
        .req_perm(req_perm), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_oa(rsp_oa), .rsp_perm(rsp_perm), .rsp_level(rsp_level),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    typedef struct {
        bit          hit;
        logic [47:0] oa;
        logic [1:0]  perm;
        logic [1:0]  lvl;
        int          due;
        string       tag;
    } exp_t;

    exp_t  expq[$];
    int    n_tests = 0, n_fail = 0, cyc = 0, exp_hits = 0, exp_miss = 0;
    bit    prev_rsp = 1'b0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [15:0] asid, input bit any,
                         input logic [47:0] addr, input logic [1:0] tg, input logic [5:0] tsz,
                         input logic [1:0] lvl, input logic [15:0] pages,
                         input logic [47:0] oa, input logic [1:0] perm,
                         output int acc, output bit rdy);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_asid = asid; req_any_asid = any;
        req_addr = addr; req_tg = tg; req_tsz = tsz; req_level = lvl;
        req_pages = pages; req_oa = oa; req_perm = perm;
        @(posedge clk);
        #1 acc = cyc;
        @(negedge clk);
        rdy = req_ready;
        req_valid = 1'b0;
    endtask

    task automatic lk(input logic [15:0] asid, input logic [47:0] addr, input logic [1:0] tg,
                      input logic [5:0] tsz, input bit hit, input logic [47:0] oa,
                      input logic [1:0] perm, input logic [1:0] lvl, input int start,
                      input string tag);
        int acc; bit r; exp_t e;
        drive(3'd0, asid, 1'b0, addr, tg, tsz, 2'd0, 16'd0, '0, '0, acc, r);
        e.hit = hit; e.oa = oa; e.perm = perm; e.lvl = lvl; e.tag = tag;
        e.due = acc + (hit ? int'(lvl) - start + 1 : 4 - start);
        expq.push_back(e);
        if (hit) exp_hits++; else exp_miss++;
    endtask

    task automatic ins(input logic [15:0] asid, input logic [47:0] addr, input logic [1:0] lvl,
                       input logic [47:0] oa, input logic [1:0] perm, output bit rdy);
        int acc;
        drive(3'd1, asid, 1'b0, addr, 2'd1, 6'd0, lvl, 16'd0, oa, perm, acc, rdy);
    endtask

    task automatic kill(input logic [2:0] op, input logic [15:0] asid, input bit any,
                        input logic [47:0] addr, input logic [1:0] tg, input logic [1:0] hint,
                        input logic [15:0] pages, output bit rdy);
        int acc;
        drive(op, asid, any, addr, tg, 6'd0, hint, pages, '0, '0, acc, rdy);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && rsp_valid) begin
            if (prev_rsp) chk(1'b0, "R12", "pulse longer than one clock", 1, 0);
            if (expq.size() == 0) begin
                chk(1'b0, "R12", "unexpected response", 1, 0);
            end else begin
                e = expq.pop_front();
                chk(rsp_hit == e.hit, e.tag, "hit flag", rsp_hit, e.hit);
                chk(cyc == e.due, e.tag, "response clock", cyc, e.due);
                if (e.hit) begin
                    chk(rsp_oa == e.oa, e.tag, "output address", rsp_oa, e.oa);
                    chk({rsp_perm, rsp_level} == {e.perm, e.lvl}, e.tag, "perm/level",
                        {rsp_perm, rsp_level}, {e.perm, e.lvl});
                end
            end
        end
        prev_rsp = rsp_valid;
    end

    initial begin
        #3000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    localparam logic [47:0] OA_A = 48'h00AA_AAAA_A000, OA_B = 48'h00BB_B000_0000;
    localparam logic [47:0] OA_C = 48'h00CC_0000_0000, OA_D = 48'h00DD_D000_0000;
    localparam logic [47:0] OA_G = 48'h0077_7000_0000, OA_H = 48'h0044_4000_0000;

    initial begin
        bit r;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
        chk(hit_count == 0 && miss_count == 0, "R1", "counters after reset",
            {hit_count, miss_count}, 0);
        rst_n = 1'b1;
        lk(16'd1, 48'h1234_5678_9000, 2'd1, 6'd16, 0, '0, '0, 2'd3, 0, "R1");

        // R3 R4 page and block hits
        ins(16'd1, 48'h0000_4000_3000, 2'd3, OA_A, 2'd3, r);
        lk(16'd1, 48'h0000_4000_3abc, 2'd1, 6'd16, 1, OA_A, 2'd3, 2'd3, 0, "R4");
        ins(16'd1, 48'h0000_8020_0000, 2'd2, OA_B, 2'd1, r);
        lk(16'd1, 48'h0000_8031_2345, 2'd1, 6'd16, 1, OA_B, 2'd1, 2'd2, 0, "R3");
        lk(16'd2, 48'h0000_8031_2345, 2'd1, 6'd16, 0, '0, '0, 2'd3, 0, "R4");
        // R2 start levels
        lk(16'd1, 48'h0000_4000_3000, 2'd3, 6'd16, 0, '0, '0, 2'd3, 1, "R2");
        lk(16'd1, 48'h0000_8031_2345, 2'd1, 6'd25, 1, OA_B, 2'd1, 2'd2, 1, "R2");

        // R3 first level wins
        ins(16'd2, 48'h0000_C000_0000, 2'd1, OA_C, 2'd2, r);
        ins(16'd2, 48'h0000_C000_5000, 2'd3, OA_D, 2'd0, r);
        lk(16'd2, 48'h0000_C000_5010, 2'd1, 6'd16, 1, OA_C, 2'd2, 2'd1, 0, "R3");
        lk(16'd2, 48'h0000_C000_5010, 2'd1, 6'd48, 1, OA_D, 2'd0, 2'd3, 3, "R2");

        // R8 by ID
        kill(3'd3, 16'd2, 1'b0, '0, 2'd1, 2'd0, 16'd0, r);
        lk(16'd2, 48'h0000_C000_5010, 2'd1, 6'd16, 0, '0, '0, 2'd3, 0, "R8");
        lk(16'd1, 48'h0000_4000_3abc, 2'd1, 6'd16, 1, OA_A, 2'd3, 2'd3, 0, "R8");

        // R9 range scan
        ins(16'd3, 48'h0000_1000_0000, 2'd3, 48'h1, 2'd3, r);
        ins(16'd3, 48'h0000_1000_1000, 2'd3, 48'h2, 2'd3, r);
        ins(16'd3, 48'h0000_1000_8000, 2'd3, OA_G, 2'd3, r);
        kill(3'd4, 16'd3, 1'b0, 48'h0000_1000_0000, 2'd0, 2'd0, 16'd2, r);
        lk(16'd3, 48'h0000_1000_0000, 2'd1, 6'd16, 0, '0, '0, 2'd3, 0, "R9");
        lk(16'd3, 48'h0000_1000_1000, 2'd1, 6'd16, 0, '0, '0, 2'd3, 0, "R9");
        lk(16'd3, 48'h0000_1000_8000, 2'd1, 6'd16, 1, OA_G, 2'd3, 2'd3, 0, "R9");
        kill(3'd4, 16'd0, 1'b1, 48'h0000_8030_0000, 2'd1, 2'd0, 16'd1, r);
        lk(16'd1, 48'h0000_8031_2345, 2'd1, 6'd16, 0, '0, '0, 2'd3, 0, "R9");
        lk(16'd1, 48'h0000_4000_3abc, 2'd1, 6'd16, 1, OA_A, 2'd3, 2'd3, 0, "R9");
        lk(16'd3, 48'h0000_1000_8000, 2'd1, 6'd16, 1, OA_G, 2'd3, 2'd3, 0, "R9");
        kill(3'd4, 16'd5, 1'b0, 48'h0000_4000_3000, 2'd1, 2'd0, 16'd1, r);
        lk(16'd1, 48'h0000_4000_3abc, 2'd1, 6'd16, 1, OA_A, 2'd3, 2'd3, 0, "R9");

        // R10 exact key removal with fallback
        ins(16'd4, 48'h0000_2000_0000, 2'd2, OA_H, 2'd1, r);
        ins(16'd4, 48'h0000_2000_0000, 2'd3, 48'h9, 2'd2, r);
        kill(3'd4, 16'd4, 1'b0, 48'h0000_2000_0000, 2'd1, 2'd3, 16'd1, r);
        lk(16'd4, 48'h0000_2000_0000, 2'd1, 6'd48, 0, '0, '0, 2'd3, 3, "R10");
        lk(16'd4, 48'h0000_2000_0000, 2'd1, 6'd16, 1, OA_H, 2'd1, 2'd2, 0, "R10");
        ins(16'd4, 48'h0000_3000_0000, 2'd3, 48'h5, 2'd1, r);
        kill(3'd4, 16'd4, 1'b0, 48'h0000_3000_0000, 2'd1, 2'd2, 16'd1, r);
        lk(16'd4, 48'h0000_3000_0000, 2'd1, 6'd48, 0, '0, '0, 2'd3, 3, "R10");
        lk(16'd4, 48'h0000_2000_0000, 2'd1, 6'd16, 1, OA_H, 2'd1, 2'd2, 0, "R10");

        // R7 invalidate everything
        kill(3'd2, 16'd0, 1'b0, '0, 2'd1, 2'd0, 16'd0, r);
        lk(16'd1, 48'h0000_4000_3abc, 2'd1, 6'd16, 0, '0, '0, 2'd3, 0, "R7");
        lk(16'd4, 48'h0000_2000_0000, 2'd1, 6'd16, 0, '0, '0, 2'd3, 0, "R7");

        // R6 fill, then insert into a full cache
        for (int k = 0; k < 8; k++)
            ins(16'd6, 48'h1000 * (k + 1), 2'd3, 48'h5000_0000 + 48'h1000 * k, 2'd2, r);
        lk(16'd6, 48'h8000, 2'd1, 6'd16, 1, 48'h5000_7000, 2'd2, 2'd3, 0, "R6");
        ins(16'd6, 48'h0000_9000_0000, 2'd3, 48'h9999_0000, 2'd1, r);
        chk(r == 1'b0, "R6", "ready during refill", r, 0);
        lk(16'd6, 48'h1000, 2'd1, 6'd16, 0, '0, '0, 2'd3, 0, "R6");
        lk(16'd6, 48'h8000, 2'd1, 6'd16, 0, '0, '0, 2'd3, 0, "R6");
        lk(16'd6, 48'h0000_9000_0000, 2'd1, 6'd16, 1, 48'h9999_0000, 2'd1, 2'd3, 0, "R6");

        // R11 reserved op codes
        kill(3'd7, 16'd6, 1'b1, 48'h0000_9000_0000, 2'd1, 2'd3, 16'd1, r);
        chk(r == 1'b1, "R11", "ready after reserved op", r, 1);
        kill(3'd5, 16'd6, 1'b1, 48'h0000_9000_0000, 2'd1, 2'd0, 16'd1, r);
        lk(16'd6, 48'h0000_9000_0000, 2'd1, 6'd16, 1, 48'h9999_0000, 2'd1, 2'd3, 0, "R11");

        while (expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(hit_count == 32'(exp_hits), "R5", "hit counter", hit_count, exp_hits);
        chk(miss_count == 32'(exp_miss), "R5", "miss counter", miss_count, exp_miss);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule